// File: doc/BRIEF.md
# Handshaked Counter Snapshot Crossing

This block hands the value of a free-running counter from its source clock domain to a reader in an unrelated clock domain. The two clocks have no phase relationship. The reader never samples the counter bits directly, and never samples them through a plain register stage either. Instead, the reader asks for a value and the source side takes a snapshot into a holding register that only the source clock writes. The reader copies that register once the handshake shows that it has settled.

The handshake uses a single request flag. The reader side sets it and the source side clears it. The flag is formed as the XOR of two toggle registers, one in each domain, so neither domain ever writes the other's flop. Each side sees the remote toggle through a multi-stage synchronizer.

When the source side sees the flag raised, it lets a guard interval of whole source clocks pass. On the next source edge it copies the counter into the holding register and flips its own toggle in the same cycle, which clears the flag. The reader waits until it sees the flag clear, then registers the holding value and pulses a valid strobe. A request made while a transfer is still outstanding is dropped.

Top module: `snap_xfer`

## Requirements
- R1: After both resets, `rd_busy` and `rd_valid` are 0 and `rd_data` is 0, and with no request `rd_valid` never rises.
- R2: The counter is zero after a source reset and increments by exactly one on every source clock edge.
- R3: A high `rd_req` sampled on a reader edge while `rd_busy` is 0 starts a transfer, and `rd_busy` is 1 from the next reader cycle until the result is delivered.
- R4: `rd_req` while `rd_busy` is 1 is ignored: each accepted request yields exactly one `rd_valid` pulse.
- R5: `rd_valid` is high for exactly one reader cycle, and `rd_busy` is 0 in that same cycle.
- R6: The returned value is at least 3 above the count the counter had when the request was presented, because of the synchronizer stages plus the guard interval.
- R7: The returned value is strictly below the counter value at the moment of the valid strobe, and strictly greater than the previously returned value.
- R8: `rd_data` holds its value in every reader cycle without a valid strobe.
- R9: The holding register changes only on the source edge that flips the source toggle, and that flip happens only after the flag has been seen in at least two consecutive source cycles.
- R10: Every transfer completes within `MAX_WAIT` reader cycles of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source clock; runs the counter and the holding register |
| src_rst_n | input | 1 | Synchronous active-low reset, source domain |
| rd_clk | input | 1 | Reader clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, reader domain |
| rd_req | input | 1 | Request for a new snapshot, sampled on `rd_clk` |
| rd_data | output | W | Last snapshot delivered to the reader |
| rd_valid | output | 1 | One-cycle strobe marking a new `rd_data` |
| rd_busy | output | 1 | A transfer is outstanding |

## Verification
Suppose a toggle register or a synchronizer stage is wrong. The result at the ports is either a transfer that never finishes, which leaves `rd_busy` stuck high past the latency bound, or an extra or missing valid pulse within a few reader cycles of the request. Suppose instead that the capture happens too early or from the wrong source. Then the returned value falls outside the window between the count when the request was made and the count when the strobe arrives, or it fails to increase from one transfer to the next, and this shows on the first transfer after the fault. The bench moves the request point across many phase offsets between the two clocks so that each ordering of edges is covered.

// File: rtl/snap_pkg.sv
// Shared types for the counter snapshot crossing.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package snap_pkg;

    // Reader-side transfer state.
    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_WAIT = 1'b1
    } rd_state_e;

    // Source-side capture state.
    typedef enum logic [1:0] {
        SRC_IDLE  = 2'd0,
        SRC_GUARD = 2'd1
    } src_state_e;

endpackage

// File: rtl/snap_sync.sv
// Multi-stage synchronizer for one level signal entering a clock domain.
// Assumes: the input is a register output from the other domain (a toggle),
// so only one bit can change per transition; STAGES >= 2.
module snap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/snap_counter.sv
// Free-running up counter in the source domain.
// Assumes: wraps naturally at 2**W.
module snap_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    // Advance by one every source clock.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end
endmodule

// File: rtl/snap_src_ctl.sv
// Source-side controller: waits for the request flag, lets GUARD_CYCLES
// whole clocks pass, then copies the counter into the holding register and
// flips the acknowledge toggle in the same cycle.
// Assumes: req_tog_s is already synchronized into this domain.
module snap_src_ctl
    import snap_pkg::*;
#(
    parameter int W            = 32,
    parameter int GUARD_CYCLES = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] count,
    input  logic         req_tog_s,
    output logic [W-1:0] hold,
    output logic         ack_tog,
    output logic         flag
);
    localparam int GW = (GUARD_CYCLES < 1) ? 1 : $clog2(GUARD_CYCLES + 1);
    localparam logic [GW-1:0] GLAST = GW'(GUARD_CYCLES);

    src_state_e    state;
    logic [GW-1:0] gcnt;
    logic          grab;

    // Flag as seen locally: remote request toggle versus own acknowledge.
    assign flag = req_tog_s ^ ack_tog;
    assign grab = (state == SRC_GUARD) && (gcnt == GLAST);

    // Track the guard interval after the flag is first seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SRC_IDLE;
            gcnt  <= '0;
        end else begin
            case (state)
                SRC_IDLE: begin
                    gcnt <= '0;
                    if (flag) state <= SRC_GUARD;
                end
                SRC_GUARD: begin
                    if (grab) begin
                        state <= SRC_IDLE;
                        gcnt  <= '0;
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                default: state <= SRC_IDLE;
            endcase
        end
    end

    // Snapshot the counter and clear the flag on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold    <= '0;
            ack_tog <= 1'b0;
        end else if (grab) begin
            hold    <= count;
            ack_tog <= ~ack_tog;
        end
    end
endmodule

// File: rtl/snap_rd_ctl.sv
// Reader-side controller: raises the request flag by flipping its toggle,
// waits until the synchronized flag reads clear, then registers the
// holding value and strobes valid for one cycle.
// Assumes: ack_tog_s is already synchronized; hold is stable whenever the
// synchronized flag reads clear.
module snap_rd_ctl
    import snap_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic         ack_tog_s,
    input  logic [W-1:0] hold,
    output logic         req_tog,
    output logic [W-1:0] data,
    output logic         valid,
    output logic         busy,
    output logic         flag
);
    rd_state_e state;

    // Flag as seen locally: own request toggle versus remote acknowledge.
    assign flag = req_tog ^ ack_tog_s;
    assign busy = (state == RD_WAIT);

    // Accept requests when idle and complete on the flag clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RD_IDLE;
            req_tog <= 1'b0;
            valid   <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (state)
                RD_IDLE: begin
                    if (req) begin
                        req_tog <= ~req_tog;
                        state   <= RD_WAIT;
                    end
                end
                RD_WAIT: begin
                    if (!flag) begin
                        valid <= 1'b1;
                        state <= RD_IDLE;
                    end
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    // Copy the settled holding register once the flag reads clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                         data <= '0;
        else if (state == RD_WAIT && !flag) data <= hold;
    end
endmodule

// File: rtl/snap_xfer.sv
// Top level of the counter snapshot crossing: counter and capture logic
// in the source domain, request and delivery logic in the reader domain,
// one synchronizer per direction for the toggles.
// Assumes: the clocks are unrelated; the resets are independent and are
// applied together at start-up.
module snap_xfer #(
    parameter int W            = 32,
    parameter int SYNC_STAGES  = 2,
    parameter int GUARD_CYCLES = 1
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic         rd_clk,
    input  logic         rd_rst_n,
    input  logic         rd_req,
    output logic [W-1:0] rd_data,
    output logic         rd_valid,
    output logic         rd_busy
);
    logic [W-1:0] cnt_w;
    logic [W-1:0] hold_w;
    logic         req_tog_w;
    logic         ack_tog_w;
    logic         req_tog_s;
    logic         ack_tog_s;
    logic         src_flag_w;
    logic         rd_flag_w;

    snap_counter #(.W(W)) u_cnt (
        .clk   (src_clk),
        .rst_n (src_rst_n),
        .count (cnt_w)
    );

    snap_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (src_clk),
        .rst_n (src_rst_n),
        .d     (req_tog_w),
        .q     (req_tog_s)
    );

    snap_src_ctl #(.W(W), .GUARD_CYCLES(GUARD_CYCLES)) u_src (
        .clk       (src_clk),
        .rst_n     (src_rst_n),
        .count     (cnt_w),
        .req_tog_s (req_tog_s),
        .hold      (hold_w),
        .ack_tog   (ack_tog_w),
        .flag      (src_flag_w)
    );

    snap_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (ack_tog_w),
        .q     (ack_tog_s)
    );

    snap_rd_ctl #(.W(W)) u_rd (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .req       (rd_req),
        .ack_tog_s (ack_tog_s),
        .hold      (hold_w),
        .req_tog   (req_tog_w),
        .data      (rd_data),
        .valid     (rd_valid),
        .busy      (rd_busy),
        .flag      (rd_flag_w)
    );
endmodule

// File: rtl/snap_xfer_chk.sv
// Property checker for snap_xfer, attached by bind.
// Assumes: connections to the top's internal nets listed in the bind.
module snap_xfer_chk #(
    parameter int W        = 32,
    parameter int MAX_WAIT = 64
) (
    input logic         src_clk,
    input logic         src_rst_n,
    input logic         rd_clk,
    input logic         rd_rst_n,
    input logic         rd_req,
    input logic [W-1:0] rd_data,
    input logic         rd_valid,
    input logic         rd_busy,
    input logic [W-1:0] cnt,
    input logic [W-1:0] hold,
    input logic         ack_tog,
    input logic         src_flag
);
    localparam int BW = $clog2(MAX_WAIT + 2);
    logic [BW-1:0] busy_len;

    // Count reader cycles spent busy.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n || !rd_busy) busy_len <= '0;
        else if (busy_len != '1)   busy_len <= busy_len + 1'b1;
    end

    // R2
    cnt_step_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $past(src_rst_n) |-> cnt == $past(cnt) + 1'b1);

    // R3
    busy_start_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $rose(rd_busy) |-> $past(rd_req));

    // R5
    valid_pulse_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_valid |=> !rd_valid);

    // R5
    valid_ends_busy_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_valid |-> !rd_busy && $past(rd_busy));

    // R8
    data_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_valid |-> $stable(rd_data));

    // R9
    hold_only_on_grab_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        !$stable(hold) |-> !$stable(ack_tog));

    // R9
    guard_wait_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        !$stable(ack_tog) |-> $past(src_flag) && $past(src_flag, 2));

    // R10
    latency_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        busy_len <= BW'(MAX_WAIT));
endmodule

bind snap_xfer snap_xfer_chk #(.W(W)) i_chk (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .rd_clk    (rd_clk),
    .rd_rst_n  (rd_rst_n),
    .rd_req    (rd_req),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .rd_busy   (rd_busy),
    .cnt       (cnt_w),
    .hold      (hold_w),
    .ack_tog   (ack_tog_w),
    .src_flag  (src_flag_w)
);

// File: tb/test_snap_xfer.sv
`timescale 1ns/1ps
module test_snap_xfer;
    localparam int W = 32;

    logic         src_clk = 1'b0;
    logic         rd_clk  = 1'b0;
    logic         src_rst_n = 1'b0;
    logic         rd_rst_n  = 1'b0;
    logic         rd_req    = 1'b0;
    logic [W-1:0] rd_data;
    logic         rd_valid;
    logic         rd_busy;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] model_cnt = '0;
    logic [W-1:0] last_v    = '0;
    logic         have_last = 1'b0;
    logic         done      = 1'b0;
    int           rd_cycles = 0;

    snap_xfer #(.W(W)) i_snap_xfer (
        .src_clk   (src_clk),
        .src_rst_n (src_rst_n),
        .rd_clk    (rd_clk),
        .rd_rst_n  (rd_rst_n),
        .rd_req    (rd_req),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .rd_busy   (rd_busy)
    );

    // 100 MHz source clock; reader clock unrelated at 13.3 ns.
    always #5    src_clk = ~src_clk;
    always #6.65 rd_clk  = ~rd_clk;

    // Arithmetic model of the source counter (R2).
    always @(posedge src_clk) model_cnt <= src_rst_n ? model_cnt + 1'b1 : '0;

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge rd_clk) begin
        rd_cycles++;
        if (rd_cycles > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", rd_cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // One transfer: present at a negedge, follow it to the strobe.
    task automatic transfer(input int extra_reqs);
        logic [W-1:0] c0, c1, v;
        int n;
        int nvalid;
        while (rd_busy) @(negedge rd_clk);
        rd_req = 1'b1;
        c0 = model_cnt;
        @(negedge rd_clk);
        rd_req = 1'b0;
        check(rd_busy == 1'b1, "R3 busy after accept", W'(rd_busy), 1);
        n = 0;
        nvalid = 0;
        while (!rd_valid && n < 200) begin
            if (extra_reqs > 0 && rd_busy) begin
                rd_req = 1'b1;
                extra_reqs--;
            end else begin
                rd_req = 1'b0;
            end
            @(negedge rd_clk);
            n++;
        end
        rd_req = 1'b0;
        check(n < 64, "R10 latency", W'(n), 64);
        c1 = model_cnt;
        v  = rd_data;
        check(rd_valid == 1'b1, "R5 strobe seen", W'(rd_valid), 1);
        check(rd_busy == 1'b0, "R5 busy low with strobe", W'(rd_busy), 0);
        check(v >= c0 + 3, "R6 lower bound", v, c0 + 3);
        check(v < c1, "R7 below count at strobe", v, c1);
        if (have_last) check(v > last_v, "R7 increasing", v, last_v + 1);
        last_v = v;
        have_last = 1'b1;
        // Look for spurious strobes in the following cycles (R4, R5, R8).
        for (int k = 0; k < 25; k++) begin
            @(negedge rd_clk);
            if (rd_valid) nvalid++;
            if (k == 0) check(rd_valid == 1'b0, "R5 one-cycle strobe", W'(rd_valid), 0);
        end
        check(nvalid == 0, "R4 one strobe per accepted request", W'(nvalid), 0);
        check(rd_busy == 1'b0, "R4 idle after transfer", W'(rd_busy), 0);
        check(rd_data == v, "R8 data held", rd_data, v);
    endtask

    initial begin
        repeat (4) @(negedge rd_clk);
        src_rst_n = 1'b1;
        rd_rst_n  = 1'b1;
        @(negedge rd_clk);
        // R1 reset state and quiet idle.
        check(rd_busy == 1'b0, "R1 busy after reset", W'(rd_busy), 0);
        check(rd_valid == 1'b0, "R1 valid after reset", W'(rd_valid), 0);
        check(rd_data == '0, "R1 data after reset", rd_data, 0);
        begin
            int seen = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge rd_clk);
                if (rd_valid || rd_busy) seen++;
            end
            check(seen == 0, "R1 no strobe without request", W'(seen), 0);
        end
        // Sweep the request point over many phase offsets (R3, R6, R7).
        for (int gap = 0; gap < 48; gap++) begin
            transfer(0);
            repeat (gap % 11) @(negedge src_clk);
            @(negedge rd_clk);
        end
        // Requests during a transfer are dropped (R4).
        for (int e = 1; e < 6; e++) transfer(e);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule